// File: doc/BRIEF.md
# Frame-Synced PCM Serial Port

This block moves voice samples between a parallel word interface and a pair of serial data lines. It sends one transmit word and captures one receive word in every frame. A bit-clock strobe from the surrounding clock logic times the lines, and a frame sync marks where each frame begins. Each word goes most significant bit first. The first bit of a word is on the line during the bit period that follows the tick where the sync was seen. A format input selects the word length: 15 bits for linear samples or 8 bits for companded samples. The format can change between frames without changing the frame timing. The block does no companding. It carries only words of the selected width.

The frame sync comes from one of two places. It can be an external pin sampled on bit ticks, or the block can make it from a free-running tick counter that fires once every `FRAME_TICKS` ticks. The block drives the sync it acts on onto `fsync_out`, so a host can use that pin as a per-frame interrupt.

The transmit side is a valid/ready stream with a one-word holding stage. `tx_ready` is high while the holding stage is empty. A word is accepted in any cycle where `tx_valid` and `tx_ready` are both high. A held word stays until the next frame start, which moves it to the shifter and frees the stage. The source must keep the held word stable only until the handshake. If no word is held at a frame start, the frame carries all zeros. The receive side has no back-pressure, because the serial line cannot be paused. `rx_valid` is a single-cycle strobe, and the sink must take `rx_data` in that cycle.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is asserted and after it is released, before any bit tick: `tx_out`=0, `tx_oe`=0, `rx_valid`=0, `frame_done`=0, `fsync_out`=0 and `tx_ready`=1.
- R2: With `lin_mode`=1 at the sync tick, the frame carries 15 bits, MSB first. Bit 14 of the word drives `tx_out` (with `tx_oe`=1) from the sync tick until the next tick. Each later tick advances one bit. `tx_out` changes only on cycles that follow a bit tick.
- R3: With `lin_mode`=0 at the sync tick, the frame carries 8 bits. `tx_data[7:0]` goes out MSB first, and the received byte appears in `rx_data[7:0]` with bits 14:8 zero.
- R4: After the tick that ends the last bit of a word, `tx_oe` is 0 and `tx_out` is 0 until the next sync tick.
- R5: `rx_in` is sampled on the ticks that follow the sync tick, one bit per tick, MSB first. In the cycle after the last sample, `rx_valid` and `frame_done` are both 1 for exactly one cycle, and `rx_data` holds the word.
- R6: With `sync_internal`=1, a frame starts on every tick whose index since reset is a multiple of `FRAME_TICKS` (default 256). `fsync_out` is high from that tick until the next tick. `fsync_in` has no effect in this mode.
- R7: With `sync_internal`=0, a frame starts on any tick where `fsync_in` is 1, and `fsync_out` shows that tick for one tick period.
- R8: The word format is latched at the sync tick. A change of `lin_mode` during a frame does not change that frame's length.
- R9: The transmit holding stage holds one word. `tx_ready` goes to 0 after a handshake and returns to 1 only at a frame start. A word offered while `tx_ready`=0 is not taken. A frame that starts with nothing held transmits zeros.
- R10: A sync that arrives before a word is complete restarts both directions. The cut-short receive word raises no `rx_valid` or `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| sync_internal | input | 1 | 1: counter-made frame sync, 0: external sync pin |
| fsync_in | input | 1 | External frame sync, sampled on bit ticks |
| fsync_out | output | 1 | The frame sync the block acted on, one tick period wide |
| lin_mode | input | 1 | 1: 15-bit linear words, 0: 8-bit companded words |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding stage empty |
| tx_data | input | 15 | Transmit word, right-aligned |
| tx_out | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable, high while word bits are on `tx_out` |
| rx_in | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle strobe: received word ready |
| rx_data | output | 15 | Received word, right-aligned, zero-extended |
| frame_done | output | 1 | One-cycle strobe when both words have finished |

## Verification
The hardest cases to reach are those where timing events overlap. One is a sync that lands in the middle of a word. Another is a format flip after the frame has already latched its length. A third is the internal counter reaching its frame tick while the external sync pin toggles at random. The bench keeps its own count of every tick since reset so it knows exactly which tick the counter will fire on, and it toggles `fsync_in` on idle ticks to show they are ignored. Directed frames cover the restart, the format flip and a rejected second push. Randomized frames cover format, data and underrun.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    FMT_COMPANDED = 1'b0,
    FMT_LINEAR    = 1'b1
  } word_fmt_e;

  typedef enum logic {
    SYNC_FROM_PIN     = 1'b0,
    SYNC_FROM_COUNTER = 1'b1
  } sync_src_e;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_port_pkg::*;
#(
  parameter int FRAME_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic sync_internal,
  input  logic fsync_in,
  output logic sync_now,
  output logic fsync_out
);
  localparam int CW = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);

  logic [CW-1:0] tick_cnt;
  sync_src_e     src;

  assign src = sync_src_e'(sync_internal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (bit_tick) begin
      tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
    end
  end

  always_comb begin
    if (src == SYNC_FROM_COUNTER) sync_now = bit_tick && (tick_cnt == '0);
    else                          sync_now = bit_tick && fsync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fsync_out <= 1'b0;
    else if (bit_tick) fsync_out <= sync_now;
  end
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int LIN_W = 15,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             sync_now,
  input  logic             lin_mode,
  input  logic             tx_valid,
  input  logic [LIN_W-1:0] tx_data,
  output logic             tx_ready,
  output logic             tx_out,
  output logic             tx_oe,
  output logic             frame_done
);
  localparam int NW = $clog2(LIN_W + 1);
  localparam int PAD = LIN_W - CMP_W;

  logic             hold_full;
  logic [LIN_W-1:0] hold_word;
  logic [LIN_W-1:0] shreg;
  logic [LIN_W-1:0] load_word;
  logic             busy;
  logic [NW-1:0]    bit_idx;
  logic [NW-1:0]    last_idx;
  logic             accept;
  word_fmt_e        fmt;

  assign fmt      = word_fmt_e'(lin_mode);
  assign tx_ready = !hold_full;
  assign accept   = tx_valid && !hold_full;
  assign tx_out   = busy && shreg[LIN_W-1];
  assign tx_oe    = busy;

  always_comb begin
    logic [LIN_W-1:0] src;
    src = hold_full ? hold_word : '0;
    if (fmt == FMT_LINEAR) load_word = src;
    else                   load_word = {src[CMP_W-1:0], {PAD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_word <= '0;
    end else begin
      if (sync_now)    hold_full <= accept;
      else if (accept) hold_full <= 1'b1;
      if (accept) hold_word <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      busy       <= 1'b0;
      bit_idx    <= '0;
      last_idx   <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (sync_now) begin
        shreg    <= load_word;
        busy     <= 1'b1;
        bit_idx  <= '0;
        last_idx <= (fmt == FMT_LINEAR) ? NW'(LIN_W - 1) : NW'(CMP_W - 1);
      end else if (bit_tick && busy) begin
        shreg   <= shreg << 1;
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == last_idx) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
#(
  parameter int LIN_W = 15,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             sync_now,
  input  logic             lin_mode,
  input  logic             rx_in,
  output logic             rx_valid,
  output logic [LIN_W-1:0] rx_data
);
  localparam int NW = $clog2(LIN_W + 1);

  logic [LIN_W-1:0] shreg;
  logic             busy;
  logic [NW-1:0]    bit_idx;
  logic [NW-1:0]    last_idx;
  word_fmt_e        fmt;

  assign fmt = word_fmt_e'(lin_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      busy     <= 1'b0;
      bit_idx  <= '0;
      last_idx <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (sync_now) begin
        shreg    <= '0;
        busy     <= 1'b1;
        bit_idx  <= '0;
        last_idx <= (fmt == FMT_LINEAR) ? NW'(LIN_W - 1) : NW'(CMP_W - 1);
      end else if (bit_tick && busy) begin
        shreg   <= {shreg[LIN_W-2:0], rx_in};
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == last_idx) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= {shreg[LIN_W-2:0], rx_in};
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int LIN_W       = 15,
  parameter int CMP_W       = 8,
  parameter int FRAME_TICKS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             sync_internal,
  input  logic             fsync_in,
  output logic             fsync_out,
  input  logic             lin_mode,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [LIN_W-1:0] tx_data,
  output logic             tx_out,
  output logic             tx_oe,
  input  logic             rx_in,
  output logic             rx_valid,
  output logic [LIN_W-1:0] rx_data,
  output logic             frame_done
);
  logic sync_now;

  pcm_frame_timer #(.FRAME_TICKS(FRAME_TICKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .sync_internal(sync_internal), .fsync_in(fsync_in),
    .sync_now(sync_now), .fsync_out(fsync_out)
  );

  pcm_tx_path #(.LIN_W(LIN_W), .CMP_W(CMP_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_now(sync_now),
    .lin_mode(lin_mode), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_out(tx_out), .tx_oe(tx_oe),
    .frame_done(frame_done)
  );

  pcm_rx_path #(.LIN_W(LIN_W), .CMP_W(CMP_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_now(sync_now),
    .lin_mode(lin_mode), .rx_in(rx_in), .rx_valid(rx_valid),
    .rx_data(rx_data)
  );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic fsync_out,
  input logic tx_ready,
  input logic tx_out,
  input logic tx_oe,
  input logic rx_valid,
  input logic frame_done
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!tx_oe && !rx_valid && !frame_done && tx_ready && !fsync_out));

  assert_tx_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(tx_out));

  assert_oe_starts_at_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> ($past(bit_tick) && fsync_out));

  assert_line_low_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_out);

  assert_rx_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_done_with_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done == rx_valid);

  assert_sync_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_out) |-> $past(bit_tick));

  assert_ready_returns_at_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> ($past(bit_tick) && fsync_out));
endmodule

bind pcm_serial_port pcm_serial_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync_out(fsync_out),
  .tx_ready(tx_ready), .tx_out(tx_out), .tx_oe(tx_oe),
  .rx_valid(rx_valid), .frame_done(frame_done)
);

// File: tb/test_pcm_serial_port.sv
`timescale 1ns/1ps
module test_pcm_serial_port;
  localparam int FT = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        sync_internal = 1'b0;
  logic        fsync_in = 1'b0;
  logic        fsync_out;
  logic        lin_mode = 1'b1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [14:0] tx_data = '0;
  logic        tx_out;
  logic        tx_oe;
  logic        rx_in = 1'b0;
  logic        rx_valid;
  logic [14:0] rx_data;
  logic        frame_done;

  int checks = 0;
  int failures = 0;
  int tick_count = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pcm_serial_port #(.LIN_W(15), .CMP_W(8), .FRAME_TICKS(FT)) i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_internal(sync_internal),
    .fsync_in(fsync_in), .fsync_out(fsync_out), .lin_mode(lin_mode),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_out(tx_out), .tx_oe(tx_oe), .rx_in(rx_in), .rx_valid(rx_valid),
    .rx_data(rx_data), .frame_done(frame_done)
  );

  function automatic logic [14:0] fit(input bit lin, input logic [14:0] w);
    return lin ? w : {7'd0, w[7:0]};
  endfunction

  function automatic bit nth_bit(input bit lin, input logic [14:0] w, input int k);
    int n;
    n = lin ? 15 : 8;
    return w[n-1-k];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic rb);
    @(negedge clk);
    fsync_in = fs; rx_in = rb; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    tick_count++;
  endtask

  task automatic push(input logic [14:0] w);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R9 ready before push", tx_ready, 1);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R9 ready after push", tx_ready, 0);
  endtask

  task automatic frame(input bit lin, input logic [14:0] txw, input logic [14:0] rxw,
                       input bit pushed, input bit flip);
    int n;
    logic [14:0] exp_tx;
    string tag;
    n = lin ? 15 : 8;
    tag = lin ? "R2" : "R3";
    exp_tx = pushed ? fit(lin, txw) : 15'd0;
    lin_mode = lin;
    tick(sync_internal ? 1'($urandom) : 1'b1, 1'b0);
    chk(tx_oe == 1'b1, "R2 oe at sync", tx_oe, 1);
    chk(fsync_out == 1'b1, sync_internal ? "R6 fsync_out" : "R7 fsync_out", fsync_out, 1);
    chk(tx_ready == 1'b1, "R9 hold freed at sync", tx_ready, 1);
    if (flip) lin_mode = !lin;
    for (int k = 0; k < n; k++) begin
      chk(tx_out == nth_bit(lin, exp_tx, k) && tx_oe,
          flip ? "R8 tx bit" : (pushed ? tag : "R9 underrun zeros"),
          {tx_oe, tx_out}, {1'b1, nth_bit(lin, exp_tx, k)});
      tick(sync_internal ? 1'($urandom) : 1'b0, nth_bit(lin, rxw, k));
      if (k == 0) chk(fsync_out == 1'b0, "R6 sync one tick wide", fsync_out, 0);
      if (k == n - 1) begin
        chk(rx_valid && frame_done && rx_data == fit(lin, rxw),
            lin ? "R5 rx word" : "R3 rx byte", rx_data, fit(lin, rxw));
      end else if (k % 4 == 1) begin
        chk(!rx_valid && !frame_done, flip ? "R8 no early strobe" : "R5 no early strobe",
            rx_valid, 0);
      end
    end
    @(negedge clk);
    chk(!rx_valid, "R5 strobe one cycle", rx_valid, 0);
    chk(!tx_oe && !tx_out, "R4 idle line", {tx_oe, tx_out}, 0);
    lin_mode = lin;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [14:0] w1, w2, rw;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!tx_oe && !rx_valid && tx_ready && !fsync_out && !frame_done, "R1 in reset",
        {tx_oe, rx_valid, tx_ready, fsync_out}, 4'b0010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_oe && !tx_out && !rx_valid && tx_ready && !fsync_out, "R1 after release",
        {tx_oe, tx_out, rx_valid, tx_ready, fsync_out}, 5'b00010);

    // Directed: linear, companded, underrun
    push(15'h5A3C); frame(1, 15'h5A3C, 15'h2B71, 1, 0);
    push(15'h7FA5); frame(0, 15'h7FA5, 15'h00C3, 1, 0);
    frame(1, 15'h0, 15'h7FFF, 0, 0);

    // R9: second offer while full is refused
    push(15'h1234);
    @(negedge clk); tx_valid = 1'b1; tx_data = 15'h6666;
    @(negedge clk); tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R9 still full", tx_ready, 0);
    frame(1, 15'h1234, 15'h0F0F, 1, 0);

    // R8: flip format mid-frame, both directions
    push(15'h4D2E); frame(1, 15'h4D2E, 15'h3579, 1, 1);
    push(15'h00B6); frame(0, 15'h00B6, 15'h005A, 1, 1);

    // R10: early sync restarts the frame
    push(15'h7001);
    tick(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      tick(1'b0, 1'b1);
      chk(!rx_valid && !frame_done, "R10 no strobe on cut word", rx_valid, 0);
    end
    push(15'h2C4B);
    frame(1, 15'h2C4B, 15'h1111, 1, 0);

    // R7: idle ticks with sync low start nothing
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 1'($urandom));
      chk(!tx_oe && !fsync_out, "R7 no sync no frame", {tx_oe, fsync_out}, 0);
    end

    // Random external frames
    for (int f = 0; f < 24; f++) begin
      bit lin, pushed;
      lin = 1'($urandom); pushed = ($urandom % 4) != 0;
      w1 = 15'($urandom); rw = 15'($urandom);
      if (pushed) push(w1);
      frame(lin, w1, rw, pushed, 0);
      repeat ($urandom % 3) tick(1'b0, 1'b0);
    end

    // Internal sync: pin noise ignored, frame on counter multiples
    sync_internal = 1'b1;
    for (int f = 0; f < 3; f++) begin
      bit lin;
      lin = 1'($urandom);
      w2 = 15'($urandom); rw = 15'($urandom);
      push(w2);
      while (tick_count % FT != 0) begin
        tick(1'($urandom), 1'b0);
        if (tick_count % 37 == 0)
          chk(!tx_oe && !fsync_out, "R6 pin ignored", {tx_oe, fsync_out}, 0);
      end
      frame(lin, w2, rw, 1, 0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule